// File: doc/BRIEF.md
# Colour Grading Table Access Port

This block holds six small colour-grading lookup tables and gives a host two ways into them through one narrow register pair. The host first writes a 16-bit control word. That word picks a table, a starting entry and an access mode. The host then reads or writes entries through a single 16-bit data register. In bulk mode each data access moves the entry pointer forward by one, so a whole table can be loaded or dumped with back-to-back data accesses and no control writes in between.

The tables do not all store the same width. Writes are cut down to the width of the chosen table. Reads are widened back to 16 bits, with sign extension for signed tables and zero fill for unsigned ones. A separate read-only lookup port lets a pixel pipeline fetch any entry by table code and index, one cycle after it asks. Reserved table codes select no storage.

Top module: `grade_table_port`

## Requirements
- R1: After synchronous reset, every entry of every table reads 0, the control word reads 0, and both host_rdata and pix_data are 0.
- R2: A control write keeps bits 9:0 of host_wdata. Bits 15:10 always read back as 0. Bits 9:7 are the table code, bits 6:1 are the entry index, and bit 0 is the bulk-mode flag.
- R3: With bit 0 of the control word at 0, every data access uses the stored index, and the index does not change.
- R4: With bit 0 at 1 and a valid table code, the index rises by one after each data read or data write. It wraps from 63 to 0, and the new index is visible in a control read.
- R5: Table widths follow the table code. Code 0 holds 14-bit signed values. Codes 1, 2 and 3 hold 12-bit unsigned values. Codes 4 and 5 hold 13-bit signed values. A write keeps only the low bits that fit the table. A read returns the value sign-extended (codes 0, 4, 5) or zero-extended (codes 1 to 3) to 16 bits.
- R6: With table code 6 or 7, a data write changes no table, a data read returns 0, and neither one moves the index.
- R7: host_rdata takes its new value at the clock edge that samples host_rd, and holds that value while host_rd is low. host_sel 0 selects the control word and host_sel 1 selects the data register.
- R8: pix_data shows the entry at pix_table and pix_index one clock after they are presented, extended as in R5. A reserved pix_table code gives 0.
- R9: When a host write and a pixel lookup hit the same entry at the same edge, the lookup returns the value held before the write. The new value appears on the following lookup.
- R10: Each table is separate storage: writing an entry in one table leaves the same index in every other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the control word, 1 selects the data register |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Registered host read value |
| pix_table | input | 3 | Table code for the pixel lookup |
| pix_index | input | 6 | Entry index for the pixel lookup |
| pix_data | output | 16 | Registered, extended pixel lookup result |

## Verification
The hardest cases to reach from the ports are the bulk walk that crosses index 63 and a host write that lands on the very entry the pixel port is reading at the same edge. Directed sequences set the index to 62 in bulk mode and run several accesses through the wrap. They also line up a pixel lookup with a data write to the same table and index. Random traffic then mixes control writes across all eight codes (reserved ones included) with reads, writes and lookups, all compared against a reference model that mirrors the tables, the index and the extension rules.

// File: rtl/grade_pkg.sv
package grade_pkg;

    localparam int DATA_W    = 16;
    localparam int IDX_W     = 6;
    localparam int TBL_COUNT = 6;
    localparam int CODE_W    = 3;
    localparam int CODE_SPAN = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        TBL_HUE_HUE = 3'd0,
        TBL_HUE_SAT = 3'd1,
        TBL_LIT_SAT = 3'd2,
        TBL_SAT_SAT = 3'd3,
        TBL_LIT_LIT = 3'd4,
        TBL_HUE_LIT = 3'd5,
        TBL_RSV_A   = 3'd6,
        TBL_RSV_B   = 3'd7
    } tbl_code_e;

    typedef struct packed {
        logic [5:0]       rsvd;
        tbl_code_e        tbl;
        logic [IDX_W-1:0] idx;
        logic             bulk;
    } ctrl_word_t;

    function automatic int tbl_width(input int code);
        case (code)
            0:       return 14;
            1, 2, 3: return 12;
            default: return 13;
        endcase
    endfunction

    function automatic bit tbl_signed(input int code);
        return (code == 0) || (code == 4) || (code == 5);
    endfunction

    function automatic logic tbl_valid(input logic [CODE_W-1:0] code);
        return code < CODE_W'(TBL_COUNT);
    endfunction

endpackage

// File: rtl/grade_bank.sv
module grade_bank
    import grade_pkg::*;
#(
    parameter int VAL_W  = 12,
    parameter bit SIGNED = 1'b0,
    parameter int DEPTH  = 64,
    parameter int DW     = DATA_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] haddr,
    output logic [DW-1:0] hdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);

    logic [VAL_W-1:0] mem [DEPTH];
    logic [DW-1:0]    pdata_q;
    logic             unused_hi;

    assign unused_hi = ^wdata[DW-1:VAL_W];

    function automatic logic [DW-1:0] widen(input logic [VAL_W-1:0] v);
        if (SIGNED) return {{(DW-VAL_W){v[VAL_W-1]}}, v};
        else        return {{(DW-VAL_W){1'b0}}, v};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            pdata_q <= '0;
        end else begin
            if (we) mem[waddr] <= wdata[VAL_W-1:0];
            pdata_q <= widen(mem[paddr]);
        end
    end

    assign hdata = widen(mem[haddr]);
    assign pdata = pdata_q;

endmodule

// File: rtl/grade_ctrl.sv
module grade_ctrl
    import grade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic              data_acc,
    output ctrl_word_t        ctrl
);

    ctrl_word_t ctrl_q;
    ctrl_word_t ctrl_in;
    logic       unused_rsvd;

    assign unused_rsvd = ^ctrl_wdata[15:10];

    always_comb begin
        ctrl_in      = ctrl_word_t'(ctrl_wdata);
        ctrl_in.rsvd = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_in;
        end else if (data_acc && ctrl_q.bulk && tbl_valid(ctrl_q.tbl)) begin
            ctrl_q.idx <= ctrl_q.idx + 1'b1;
        end
    end

    assign ctrl = ctrl_q;

    // R4
    bulk_step_chk: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ctrl_we && ctrl_q.bulk && tbl_valid(ctrl_q.tbl))
        |=> ctrl_q.idx == IDX_W'($past(ctrl_q.idx) + 1'b1));

    // R3
    normal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ctrl_we && !ctrl_q.bulk) |=> $stable(ctrl_q.idx));

    // R6
    rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !ctrl_we && !tbl_valid(ctrl_q.tbl)) |=> $stable(ctrl_q.idx));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> ctrl_q.rsvd == '0 && ctrl_q.idx == $past(ctrl_wdata[6:1]));

endmodule

// File: rtl/grade_table_port.sv
module grade_table_port
    import grade_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic [2:0]  pix_table,
    input  logic [5:0]  pix_index,
    output logic [15:0] pix_data
);

    ctrl_word_t        ctrl;
    logic              data_acc;
    logic              ctrl_we;
    logic [DATA_W-1:0] hdata_a [CODE_SPAN];
    logic [DATA_W-1:0] pdata_a [CODE_SPAN];
    logic [CODE_W-1:0] pix_tbl_q;
    logic [DATA_W-1:0] rdata_q;

    assign data_acc = host_sel && (host_wr || host_rd);
    assign ctrl_we  = !host_sel && host_wr;

    grade_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (host_wdata),
        .data_acc   (data_acc),
        .ctrl       (ctrl)
    );

    for (genvar t = 0; t < CODE_SPAN; t++) begin : g_tbl
        if (t < TBL_COUNT) begin : g_bank
            grade_bank #(
                .VAL_W  (tbl_width(t)),
                .SIGNED (tbl_signed(t)),
                .DEPTH  (1 << IDX_W)
            ) u_bank (
                .clk   (clk),
                .rst   (rst),
                .we    (host_wr && host_sel && (ctrl.tbl == CODE_W'(t))),
                .waddr (ctrl.idx),
                .wdata (host_wdata),
                .haddr (ctrl.idx),
                .hdata (hdata_a[t]),
                .paddr (pix_index),
                .pdata (pdata_a[t])
            );
        end else begin : g_rsv
            assign hdata_a[t] = '0;
            assign pdata_a[t] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q   <= '0;
            pix_tbl_q <= '0;
        end else begin
            pix_tbl_q <= pix_table;
            if (host_rd && !host_wr)
                rdata_q <= host_sel ? hdata_a[ctrl.tbl] : DATA_W'(ctrl);
        end
    end

    assign host_rdata = rdata_q;
    assign pix_data   = pdata_a[pix_tbl_q];

    // R6
    rsv_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_sel && !tbl_valid(ctrl.tbl)) |=> host_rdata == '0);

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));

    // R8
    pix_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !tbl_valid(pix_table) |=> pix_data == '0);

    // R5
    hue_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_table == 3'd0) |=> (pix_data[15:13] == 3'b000 || pix_data[15:13] == 3'b111));

endmodule

// File: tb/grade_table_port_test.sv
module grade_table_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_wr, host_rd, host_sel;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic [2:0]  pix_table;
    logic [5:0]  pix_index;
    logic [15:0] pix_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] mdl [8][64];
    logic [15:0] mctrl;

    always #2.5 clk = ~clk;

    grade_table_port uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_table(pix_table), .pix_index(pix_index), .pix_data(pix_data)
    );

    function automatic logic [15:0] ext(input int code, input logic [15:0] v);
        case (code)
            0:       return {{2{v[13]}}, v[13:0]};
            1, 2, 3: return {4'h0, v[11:0]};
            4, 5:    return {{3{v[12]}}, v[12:0]};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int mtbl();
        return int'(mctrl[9:7]);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_idx();
        if (mctrl[0] && mtbl() < 6)
            mctrl[6:1] = mctrl[6:1] + 6'd1;
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b0; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        mctrl = {6'b0, v[9:0]};
    endtask

    task automatic wr_data(input logic [15:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        if (mtbl() < 6) mdl[mtbl()][mctrl[6:1]] = ext(mtbl(), v);
        step_idx();
    endtask

    task automatic rd_data(input string req);
        logic [15:0] exp;
        exp = mdl[mtbl()][mctrl[6:1]];
        @(negedge clk);
        host_rd = 1'b1; host_sel = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(req, host_rdata, exp);
        step_idx();
    endtask

    task automatic rd_ctrl(input string req);
        @(negedge clk);
        host_rd = 1'b1; host_sel = 1'b0;
        @(negedge clk);
        host_rd = 1'b0;
        chk(req, host_rdata, mctrl);
    endtask

    task automatic pix_chk(input string req, input logic [2:0] t, input logic [5:0] i);
        @(negedge clk);
        pix_table = t; pix_index = i;
        @(negedge clk);
        chk(req, pix_data, mdl[t][i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] old_v;
        void'($urandom(32'd4242));
        for (int t = 0; t < 8; t++)
            for (int i = 0; i < 64; i++) mdl[t][i] = 16'h0;
        mctrl = 16'h0;
        rst = 1'b1; host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0;
        pix_table = 0; pix_index = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", host_rdata, 16'h0);
        chk("R1 pix", pix_data, 16'h0);
        rd_ctrl("R1 ctrl");
        rd_data("R1 entry");
        pix_chk("R1 pix entry", 3'd5, 6'd33);

        // R2 control readback
        wr_ctrl(16'hFC00 | {6'b0, 3'd2, 6'd5, 1'b0});
        rd_ctrl("R2 ctrl readback");

        // R5 widths and extension
        wr_ctrl({6'b0, 3'd0, 6'd1, 1'b0});
        wr_data(16'h2000); rd_data("R5 hue-hue sign");
        wr_ctrl({6'b0, 3'd1, 6'd1, 1'b0});
        wr_data(16'hF123); rd_data("R5 sat zero-fill");
        wr_ctrl({6'b0, 3'd4, 6'd1, 1'b0});
        wr_data(16'h1000); rd_data("R5 lit negative");
        wr_data(16'h0FFF); rd_data("R5 lit positive");
        chk("R5 direct", mdl[4][1], 16'h0FFF);

        // R3 normal mode keeps the index
        wr_ctrl({6'b0, 3'd3, 6'd20, 1'b0});
        wr_data(16'h0111); wr_data(16'h0222);
        rd_data("R3 same entry"); rd_data("R3 same entry again");
        rd_ctrl("R3 index unchanged");

        // R4 bulk walk across the wrap
        wr_ctrl({6'b0, 3'd2, 6'd62, 1'b1});
        wr_data(16'h0AAA); wr_data(16'h0BBB); wr_data(16'h0CCC);
        rd_ctrl("R4 index wrapped");
        wr_ctrl({6'b0, 3'd2, 6'd62, 1'b1});
        rd_data("R4 walk 62"); rd_data("R4 walk 63"); rd_data("R4 walk 0");
        rd_ctrl("R4 index after reads");

        // R6 reserved codes
        wr_ctrl({6'b0, 3'd6, 6'd10, 1'b1});
        wr_data(16'h1234);
        rd_data("R6 read zero");
        rd_ctrl("R6 index held");
        wr_ctrl({6'b0, 3'd7, 6'd10, 1'b1});
        wr_data(16'h4321);
        rd_ctrl("R6 index held code 7");
        pix_chk("R6 pix reserved", 3'd6, 6'd10);
        for (int t = 0; t < 6; t++) pix_chk("R6 tables untouched", 3'(t), 6'd10);

        // R10 independence
        wr_ctrl({6'b0, 3'd5, 6'd40, 1'b0});
        wr_data(16'h0765);
        for (int t = 0; t < 6; t++) pix_chk("R10 same index", 3'(t), 6'd40);

        // R9 collision: old value first, new value next
        wr_ctrl({6'b0, 3'd1, 6'd7, 1'b0});
        wr_data(16'h0055);
        @(negedge clk);
        pix_table = 3'd1; pix_index = 6'd7;
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 16'h0066;
        old_v = mdl[1][7];
        @(negedge clk);
        host_wr = 1'b0;
        mdl[1][7] = ext(1, 16'h0066);
        chk("R9 old value", pix_data, old_v);
        @(negedge clk);
        chk("R9 new value", pix_data, mdl[1][7]);

        // R7 hold with no read
        rd_ctrl("R7 ctrl read");
        repeat (3) @(negedge clk);
        chk("R7 rdata held", host_rdata, mctrl);

        // random mix (R3 R4 R5 R6 R8)
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 10);
            case (r)
                0, 1: wr_ctrl({6'($urandom), 3'($urandom), 6'($urandom), 1'($urandom)});
                2, 3, 4: wr_data(16'($urandom));
                5, 6, 7: rd_data("R5 random read");
                8: rd_ctrl("R4 random ctrl");
                default: pix_chk("R8 random lookup", 3'($urandom), 6'($urandom));
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule